// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a single 32-bit control word and a slow tick enable. Software arms it with a write that carries a count field, a run/stop command bit and a 7-bit key. Once the stored word has its command bit set, the watchdog is locked. A later write takes effect only when its key is the bitwise inverse of the key held at that moment. A refresh therefore has to flip the key on every write, and a stray store of a constant value cannot keep a hung system alive.

An accepted write reloads the down-counter from the count field of the word that was stored before the write. A zero count field means half the field's range, which is 256 ticks. The written command bit then starts or stops the countdown, and the written word becomes the stored word.

Expiry escalates in two stages. The first expiry raises a non-maskable interrupt and restarts the counter with a short grace count. A second expiry while the interrupt is still high emits a one-cycle reset request and halts the counter. An accepted write in between clears the escalation and drops the interrupt.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, nmi_o and rst_req_o are low, the countdown is stopped and the stored control word is zero, so the watchdog starts unlocked.
- R2: While bit 8 of the stored word is 0, every write is accepted whatever its key bits [15:9] hold.
- R3: While bit 8 of the stored word is 1, a write whose bits [15:9] differ from the inverse of the stored bits [15:9] is discarded. It changes neither the stored word, nor the counter, nor nmi_o, nor rst_req_o.
- R4: An accepted write loads the counter from bits [8:0] of the word stored before the write. A value of 0 in that field loads 256.
- R5: An accepted write starts the countdown when its bit 8 is 1 and stops it when bit 8 is 0. A stopped counter never expires.
- R6: Each cycle with tick_i high decrements a running counter. A counter loaded with N expires on the N-th such tick after the load.
- R7: On an expiry while nmi_o is low, nmi_o rises in the next cycle and the counter restarts with GRACE_TICKS (default 1) and keeps running.
- R8: On an expiry while nmi_o is high, rst_req_o is high for exactly one cycle, starting in the next cycle. The counter stops and nmi_o stays high.
- R9: An accepted write drives nmi_o low in the next cycle and returns the escalation to its first stage.
- R10: When an accepted write and a tick arrive in the same cycle, the write takes effect and the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word: count [8:0], command [8], key [15:9] |
| tick_i | input | 1 | Slow count enable, one decrement per high cycle |
| nmi_o | output | 1 | Non-maskable interrupt, held until an accepted write or reset |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check on every cycle the following rules:
- the reset request is one cycle wide and never occurs without the interrupt,
- a discarded write leaves the stored word untouched,
- an accepted write drops the interrupt,
- a stopped counter holds its value,
- the interrupt rises only after an expiry.

The counter is reloaded from the previously stored word, not from the word being written, and a zero field loads 256. Only the bench's scenarios can show this, together with the exact tick on which each expiry lands and the priority of a write over a tick in the same cycle. A behavioural model in the bench follows these cases through runs with irregular ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned WD_DATA_W = 32;
  parameter int unsigned WD_CNT_W  = 9;
  parameter int unsigned WD_KEY_W  = 7;

  typedef enum logic {STG_ARMED = 1'b0, STG_NMI = 1'b1} wd_stage_e;
endpackage

// File: rtl/wdog_key_gate.sv
module wdog_key_gate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned KEY_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              accept_o,
  output logic              start_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int unsigned EN_BIT  = CNT_W - 1;
  localparam int unsigned KEY_LSB = CNT_W;
  localparam logic [CNT_W-1:0] ZERO_MAP = CNT_W'(1) << (CNT_W - 1);

  logic [DATA_W-1:0] ctrl_q;
  logic [KEY_W-1:0]  key_need;
  logic              locked;

  assign locked     = ctrl_q[EN_BIT];
  assign key_need   = ~ctrl_q[KEY_LSB +: KEY_W];
  assign accept_o   = wr_en_i && (!locked || (wr_data_i[KEY_LSB +: KEY_W] == key_need));
  assign start_o    = wr_data_i[EN_BIT];
  // reload uses the word held before this write
  assign load_val_o = (ctrl_q[CNT_W-1:0] == '0) ? ZERO_MAP : ctrl_q[CNT_W-1:0];
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (accept_o) ctrl_q <= wr_data_i;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned GRACE_TICKS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             grace_i,
  input  logic             halt_i,
  output logic             expire_o,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] GRACE_VAL = CNT_W'(GRACE_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step;

  assign step      = run_q && tick_i && !load_i;
  assign expire_o  = step && (cnt_q <= CNT_W'(1));
  assign running_o = run_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= start_i;
    end else if (grace_i) begin
      cnt_q <= GRACE_VAL;
    end else if (halt_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic expire_i,
  output logic grace_o,
  output logic halt_o,
  output logic nmi_o,
  output logic rst_req_o
);
  wd_stage_e stg_q;
  logic      req_q;

  assign grace_o   = expire_i && (stg_q == STG_ARMED);
  assign halt_o    = expire_i && (stg_q == STG_NMI);
  assign nmi_o     = (stg_q == STG_NMI);
  assign rst_req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= STG_ARMED;
      req_q <= 1'b0;
    end else if (clear_i) begin
      stg_q <= STG_ARMED;
      req_q <= 1'b0;
    end else begin
      req_q <= halt_o;
      if (grace_o) stg_q <= STG_NMI;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W      = WD_DATA_W,
  parameter int unsigned CNT_W       = WD_CNT_W,
  parameter int unsigned KEY_W       = WD_KEY_W,
  parameter int unsigned GRACE_TICKS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic              accept;
  logic              start;
  logic [CNT_W-1:0]  load_val;
  logic [DATA_W-1:0] ctrl_q;
  logic              expire;
  logic              running;
  logic [CNT_W-1:0]  cnt_q;
  logic              grace;
  logic              halt;

  wdog_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .accept_o   (accept),
    .start_o    (start),
    .load_val_o (load_val),
    .ctrl_o     (ctrl_q)
  );

  wdog_counter #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .start_i    (start),
    .load_val_i (load_val),
    .tick_i     (tick_i),
    .grace_i    (grace),
    .halt_i     (halt),
    .expire_o   (expire),
    .running_o  (running),
    .cnt_o      (cnt_q)
  );

  wdog_stage u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .expire_i  (expire),
    .grace_o   (grace),
    .halt_o    (halt),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              tick_i,
  input logic              nmi_o,
  input logic              rst_req_o,
  input logic              accept,
  input logic              expire,
  input logic              running,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q
);
  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_req_under_nmi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> nmi_o);

  assert_halt_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && nmi_o) |=> !running);

  assert_reject_keeps_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !accept) |=> $stable(ctrl_q));

  assert_ack_drops_nmi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !nmi_o);

  assert_nmi_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> $past(expire));

  assert_frozen_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !accept) |=> $stable(cnt_q));

  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && tick_i) |=> !rst_req_o);
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .tick_i    (tick_i),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o),
  .accept    (accept),
  .expire    (expire),
  .running   (running),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
  localparam int GRACE = 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        nmi;
  logic        rst_req;

  int    n_run = 0;
  int    n_fail = 0;
  int    wd_cycles = 0;
  string cur_req = "R1";

  // reference model state
  int unsigned m_ctrl = 0;
  int          m_cnt = 0;
  bit          m_run = 0;
  bit          m_nmi = 0;
  bit          m_req = 0;

  always #2.5 clk = ~clk;

  wdog_keyed #(.GRACE_TICKS(GRACE)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .tick_i    (tick),
    .nmi_o     (nmi),
    .rst_req_o (rst_req)
  );

  always @(posedge clk) begin
    bit ok;
    bit en;
    int unsigned old_cnt;
    if (!rst_ni) begin
      m_ctrl = 0; m_cnt = 0; m_run = 0; m_nmi = 0; m_req = 0;
    end else begin
      en = m_ctrl[8];
      ok = wr_en && (!en || (wr_data[15:9] == (~m_ctrl[15:9] & 7'h7f)));
      m_req = 0;
      if (ok) begin
        old_cnt = m_ctrl & 32'h1ff;
        m_cnt   = (old_cnt == 0) ? 256 : int'(old_cnt);
        m_run   = wr_data[8];
        m_nmi   = 0;
        m_ctrl  = wr_data;
      end else if (m_run && tick) begin
        if (m_cnt <= 1) begin
          if (!m_nmi) begin
            m_nmi = 1;
            m_cnt = GRACE;
          end else begin
            m_req = 1;
            m_run = 0;
            m_cnt = 0;
          end
        end else begin
          m_cnt--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      n_run++;
      if (nmi !== m_nmi || rst_req !== m_req) begin
        n_fail++;
        $display("FAIL %s model compare: nmi=%0b req=%0b expected nmi=%0b req=%0b",
                 cur_req, nmi, rst_req, m_nmi, m_req);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b0;
      tick  = t;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [31:0] d, input bit t);
    wr_en   = 1'b1;
    wr_data = d;
    tick    = t;
    @(negedge clk);
    wr_en   = 1'b0;
    tick    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 nmi after reset", nmi, 1'b0);
    chk("R1 req after reset", rst_req, 1'b0);
    rst_ni = 1'b1;
    cyc(20, 1'b1);
    chk("R1 stopped after reset", nmi, 1'b0);

    // R2: unlocked, any key; stage count 5 then arm with key 0x2A
    cur_req = "R2";
    wr(32'h0000_0005, 1'b0);
    wr(32'h0000_5503, 1'b0);
    // R6: loaded 5 from previously stored word
    cur_req = "R6";
    cyc(4, 1'b1);
    chk("R6 no expiry before 5th tick", nmi, 1'b0);
    cyc(1, 1'b1);
    chk("R7 nmi on first expiry", nmi, 1'b1);
    cur_req = "R8";
    cyc(1, 1'b0);
    chk("R8 no req without tick", rst_req, 1'b0);
    cyc(1, 1'b1);
    chk("R8 req after grace", rst_req, 1'b1);
    cyc(1, 1'b1);
    chk("R8 req single cycle", rst_req, 1'b0);
    chk("R8 nmi held", nmi, 1'b1);
    cyc(30, 1'b1);
    chk("R8 halted, no further req", rst_req, 1'b0);

    // R3: same key rejected while locked
    cur_req = "R3";
    wr(32'h0000_5503, 1'b1);
    chk("R3 rejected write keeps nmi", nmi, 1'b1);
    wr(32'h0000_FF00, 1'b0);
    chk("R3 wrong key keeps nmi", nmi, 1'b1);

    // R9/R4: key 0x55 accepted, loads 0x103 = 259 from stored word
    cur_req = "R9";
    wr(32'h0000_AB04, 1'b0);
    chk("R9 accepted write drops nmi", nmi, 1'b0);
    cur_req = "R4";
    cyc(258, 1'b1);
    chk("R4 reload from stored count", nmi, 1'b0);
    cyc(1, 1'b1);
    chk("R4 expiry on 259th tick", nmi, 1'b1);

    // R5: key 0x2A, command 0 -> stopped
    cur_req = "R5";
    wr(32'h0000_5400, 1'b1);
    chk("R5 write drops nmi", nmi, 1'b0);
    cyc(400, 1'b1);
    chk("R5 stopped never expires", nmi, 1'b0);

    // R4: stored count field 0 -> 256; irregular ticks
    cur_req = "R4";
    wr(32'h0000_0100, 1'b0);
    for (int i = 0; i < 255; i++) begin
      cyc(1, 1'b1);
      cyc(1, 1'b0);
    end
    chk("R4 zero field: 255 ticks no expiry", nmi, 1'b0);
    cyc(1, 1'b1);
    chk("R4 zero field: 256th tick expires", nmi, 1'b1);

    // R10: write with tick in same cycle, key 0x7F, reload 256
    cur_req = "R10";
    wr(32'h0000_FF00, 1'b1);
    chk("R10 write wins over tick", nmi, 1'b0);
    cyc(255, 1'b1);
    chk("R10 tick on write cycle ignored", nmi, 1'b0);
    cyc(1, 1'b1);
    chk("R10 expiry after full 256", nmi, 1'b1);

    // R1: reset mid-run
    cur_req = "R1";
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 nmi cleared by reset", nmi, 1'b0);
    rst_ni = 1'b1;
    cyc(300, 1'b1);
    chk("R1 stopped after reset", nmi, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule